// File: doc/BRIEF.md
# Sampling Converter Serial Port Slave

This block is the digital half of a sampling converter's serial port. A host drives a conversion-control strobe, a serial clock and a serial data line. The block runs the block-level state (idle, acquiring, converting) from the strobe. It shifts a 12-bit configuration word in from the host and shifts a 12-bit result word out. The output has a data line and a separate drive enable, which the pad ring turns into a tri-state pin. All host inputs are asynchronous. They are synchronised into the system clock and edge-detected, so the serial clock must be well below the system clock.

The converter core is abstract. A conversion lasts a fixed number of system clocks, and at its end the block latches the result presented on `conv_result_i`. Data is pipelined. The word read during one conversion belongs to the conversion before it. The configuration written now steers a later conversion, and the configuration in force is driven on `cfg_o` for the core. The bit position of a transfer survives a strobe pulse, so one word may be split around the start of a conversion without losing bits.

The output word is the 8-bit result in bits 11:4, followed by the low four bits of the configuration that the conversion used, in bits 3:0.

Top module: `adc_serial_slave`

## Requirements
- R1: In idle, a falling strobe enters acquisition. In acquisition, a rising strobe starts a conversion and `conv_busy_o` goes high. A rising strobe in idle starts nothing.
- R2: While the strobe is low, a rising serial clock captures `sdi_i`, most significant bit first. After the 12th captured bit the word becomes the active configuration on `cfg_o`.
- R3: While the strobe is low, each falling serial clock moves `sdo_o` to the next bit of the output word, starting with bit 11. Falling edges after bit 0 drive 0.
- R4: `sdo_oe_o` is low while the strobe is high and while no acquisition has yet been entered since reset.
- R5: On entry to acquisition from idle, `sdo_oe_o` rises with `sdo_o` high, before any serial clock edge. Both bit counters restart.
- R6: A strobe pulse during a transfer freezes both bit counters and the `sdo_o` value. The transfer resumes at the same bit when the strobe returns low.
- R7: A conversion uses the configuration active at its start. A configuration committed during conversion N therefore applies to conversion N+1. The word readable during conversion N is the output of conversion N-1.
- R8: At the end of each conversion the output word is overwritten with {result[7:0], cfg[3:0]}, whether or not the previous word was read.
- R9: `conv_busy_o` stays high for exactly CONV_CYCLES system clocks per conversion. The block then returns to idle.
- R10: A configuration shift of fewer than 12 bits leaves `cfg_o` unchanged.
- R11: After reset `sdo_oe_o` is 0, `conv_busy_o` is 0 and `cfg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Conversion-control strobe from host (asynchronous) |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| sdi_i | input | 1 | Serial configuration data from host |
| conv_result_i | input | RES_W (8) | Result from the converter core, taken at end of conversion |
| sdo_o | output | 1 | Serial output data |
| sdo_oe_o | output | 1 | Drive enable for the serial output pad |
| conv_busy_o | output | 1 | High while a conversion runs |
| cfg_o | output | DATA_W (12) | Active configuration word |

## Verification
The bench covers three transfer timings: a whole word shifted during acquisition, a whole word shifted during a conversion, and a word split by a strobe pulse. A design that resets its counters on every falling strobe would repeat bits after a split. A design that drives the stale output bit instead of a high level on acquisition entry would show that bit too. Configuration written mid-conversion is read back through the tag bits of the next-but-one word. A design that applies configuration immediately would show the new tag one conversion early. Two conversions run back to back without a read, to confirm that the older word is lost. A 4-bit partial write is checked against `cfg_o` to catch a design that commits partial shifts.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } adc_state_e;
endpackage

// File: rtl/adc_if_sync.sv
module adc_if_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[s] <= RST_VAL;
          else         stage_q[s] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[s] <= RST_VAL;
          else         stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= stage_q[STAGES-1];

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = stage_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_if_ctrl.sv
module adc_if_ctrl
  import adc_if_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned RES_W       = 8,
  parameter int unsigned CONV_CYCLES = 180
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_rise_i,
  input  logic              cnv_fall_i,
  input  logic              cfg_commit_i,
  input  logic [DATA_W-1:0] cfg_word_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              acq_start_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] tx_word_o
);
  localparam int unsigned TAG_W = DATA_W - RES_W;
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);

  adc_state_e        state_q;
  logic [CNT_W-1:0]  timer_q;
  logic [DATA_W-1:0] cfg_active_q, cfg_used_q, tx_word_q;

  assign acq_start_o = cnv_fall_i && (state_q == ST_IDLE);
  assign busy_o      = (state_q == ST_CONV);
  assign cfg_o       = cfg_active_q;
  assign tx_word_o   = tx_word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      timer_q    <= '0;
      cfg_used_q <= '0;
      tx_word_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cnv_fall_i) state_q <= ST_ACQ;
        ST_ACQ: if (cnv_rise_i) begin
          state_q    <= ST_CONV;
          timer_q    <= CNT_W'(CONV_CYCLES - 1);
          cfg_used_q <= cfg_active_q;
        end
        ST_CONV: begin
          if (timer_q == '0) begin
            state_q   <= ST_IDLE;
            tx_word_q <= {result_i, cfg_used_q[TAG_W-1:0]};
          end else begin
            timer_q <= timer_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           cfg_active_q <= '0;
    else if (cfg_commit_i) cfg_active_q <= cfg_word_i;

  // conversion only begins from acquisition
  p_start_from_acq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && $past(state_q) != ST_CONV) |-> $past(state_q) == ST_ACQ);

  p_conv_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q) == ST_CONV) |-> $past(timer_q) == '0);

  p_overwrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q) == ST_CONV)
      |-> tx_word_q == {$past(result_i), $past(cfg_used_q[TAG_W-1:0])});

  p_cfg_pipe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && $past(state_q) == ST_ACQ) |-> cfg_used_q == $past(cfg_active_q));
endmodule

// File: rtl/adc_if_shift.sv
module adc_if_shift #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              shift_en_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              sdo_o,
  output logic              commit_o,
  output logic [DATA_W-1:0] cfg_word_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  in_cnt_q, out_cnt_q, out_idx;
  logic [DATA_W-1:0] rx_q;
  logic              sdo_q, commit_q;

  assign out_idx    = LAST - out_cnt_q;
  assign sdo_o      = sdo_q;
  assign commit_o   = commit_q;
  assign cfg_word_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
      rx_q      <= '0;
      sdo_q     <= 1'b0;
      commit_q  <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (restart_i) begin
        in_cnt_q  <= '0;
        out_cnt_q <= '0;
        sdo_q     <= 1'b1;   // idle-high until first bit
      end else if (shift_en_i) begin
        if (sclk_rise_i && in_cnt_q != FULL) begin
          rx_q     <= {rx_q[DATA_W-2:0], sdi_i};
          in_cnt_q <= in_cnt_q + 1'b1;
          commit_q <= (in_cnt_q == LAST);
        end
        if (sclk_fall_i) begin
          if (out_cnt_q != FULL) begin
            sdo_q     <= tx_word_i[out_idx];
            out_cnt_q <= out_cnt_q + 1'b1;
          end else begin
            sdo_q <= 1'b0;
          end
        end
      end
    end
  end

  p_hold_counts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i && !restart_i |=> $stable(in_cnt_q) && $stable(out_cnt_q) && $stable(sdo_q));

  p_commit_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> in_cnt_q == FULL && $past(in_cnt_q) == LAST);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_cnt_q <= FULL && out_cnt_q <= FULL);

  p_restart_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> sdo_q && out_cnt_q == '0);
endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned RES_W       = 8,
  parameter int unsigned CONV_CYCLES = 180,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [RES_W-1:0]  conv_result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              conv_busy_o,
  output logic [DATA_W-1:0] cfg_o
);
  logic [2:0]        lvl, rise, fall;
  logic              acq_start, shift_en, commit, started_q;
  logic [DATA_W-1:0] rx_word, tx_word;

  // bit0 cnv (idles high), bit1 sclk, bit2 sdi
  adc_if_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sdi_i, sclk_i, cnv_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  adc_if_ctrl #(.DATA_W(DATA_W), .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnv_rise_i   (rise[0]),
    .cnv_fall_i   (fall[0]),
    .cfg_commit_i (commit),
    .cfg_word_i   (rx_word),
    .result_i     (conv_result_i),
    .acq_start_o  (acq_start),
    .busy_o       (conv_busy_o),
    .cfg_o        (cfg_o),
    .tx_word_o    (tx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        started_q <= 1'b0;
    else if (acq_start) started_q <= 1'b1;

  assign shift_en = ~lvl[0] & started_q;

  adc_if_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (acq_start),
    .shift_en_i  (shift_en),
    .sclk_rise_i (rise[1]),
    .sclk_fall_i (fall[1]),
    .sdi_i       (lvl[2]),
    .tx_word_i   (tx_word),
    .sdo_o       (sdo_o),
    .commit_o    (commit),
    .cfg_word_o  (rx_word)
  );

  assign sdo_oe_o = shift_en | (acq_start & ~lvl[0]);

  p_hiz_conv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_busy_o) |-> !sdo_oe_o);

  p_cfg_only_commit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit) |-> $stable(cfg_o));
endmodule

// File: tb/adc_serial_slave_tb_top.sv
module adc_serial_slave_tb_top;
  localparam int CONV = 400;
  localparam int SETTLE = 6;

  logic clk = 0, rst_n = 0, cnv = 1, sclk = 0, sdi = 0;
  logic [7:0] result = '0;
  logic sdo, sdo_oe, busy;
  logic [11:0] cfg;

  int checks = 0, failures = 0;

  // behavioural reference model
  int          m_state = 0;   // 0 idle 1 acq 2 conv
  bit          m_started = 0, m_busy = 0, m_sdo = 0;
  logic [11:0] m_word = '0, m_cfg = '0, m_used = '0, m_sh = '0;
  int          m_out = 0, m_in = 0;

  always #10 clk = ~clk;

  adc_serial_slave #(.CONV_CYCLES(CONV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnv_i(cnv), .sclk_i(sclk), .sdi_i(sdi),
    .conv_result_i(result), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .conv_busy_o(busy), .cfg_o(cfg));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare(string req);
    bit oe_exp;
    oe_exp = m_started && !cnv;
    chk({req, " oe"}, 32'(sdo_oe), 32'(oe_exp));
    if (oe_exp) chk({req, " sdo"}, 32'(sdo), 32'(m_sdo));
    chk({req, " busy"}, 32'(busy), 32'(m_busy));
    chk({req, " cfg"}, 32'(cfg), 32'(m_cfg));
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cnv_fall(string req);
    cnv = 0;
    if (m_state == 0) begin
      m_state = 1; m_started = 1; m_out = 0; m_in = 0; m_sdo = 1;
    end
    settle(); compare(req);
  endtask

  task automatic cnv_rise(string req);
    cnv = 1;
    if (m_state == 1) begin
      m_state = 2; m_busy = 1; m_used = m_cfg;
    end
    settle(); compare(req);
  endtask

  task automatic pulse(bit b, string req);
    sdi = b;
    repeat (4) @(posedge clk);
    sclk = 1;
    if (m_started && m_in < 12) begin
      m_sh = {m_sh[10:0], b}; m_in++;
      if (m_in == 12) m_cfg = m_sh;
    end
    settle(); compare(req);
    sclk = 0;
    if (m_started) begin
      if (m_out < 12) begin m_sdo = m_word[11-m_out]; m_out++; end
      else m_sdo = 0;
    end
    settle(); compare(req);
  endtask

  task automatic xfer(int first, int n, logic [11:0] d, string req);
    for (int k = first; k < first + n; k++) pulse(d[11-k], req);
  endtask

  task automatic wait_done(string req);
    while (busy) @(negedge clk);
    m_word = {result, m_used[3:0]}; m_state = 0; m_busy = 0;
    @(negedge clk);
    compare(req);
  endtask

  // R9: busy length measured at the port
  int busy_len = 0;
  bit busy_prev = 0;
  always @(posedge clk) begin
    if (busy) busy_len++;
    if (busy_prev && !busy) begin
      chk("R9 busy length", 32'(busy_len), 32'(CONV));
      busy_len = 0;
    end
    busy_prev = busy;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R11 reset");
    rst_n = 1;
    settle(); compare("R11 after reset");

    // acquisition-time transfer
    result = 8'h3C;
    cnv_fall("R5 acq entry");
    xfer(0, 12, 12'hA5C, "R2 R3 full word");
    cnv_rise("R1 start R4");
    wait_done("R8 done");

    result = 8'h81;
    cnv_fall("R5 acq entry 2");
    xfer(0, 12, 12'hA5C, "R7 tag of previous conv");
    cnv_rise("R1 start 2");
    wait_done("R8 done 2");

    // transfer during conversion; cfg written now applies to next conversion
    result = 8'h5A;
    cnv_fall("R5 acq entry 3");
    cnv_rise("R1 start 3");
    cnv_fall("R7 read during conv");
    xfer(0, 12, 12'h3E7, "R7 word of N-1");
    wait_done("R9 done with strobe low");
    cnv_rise("R1 rise in idle ignored");

    // word split around a conversion start
    result = 8'hE1;
    cnv_fall("R5 acq entry 4");
    xfer(0, 5, 12'h2B4, "R6 first part");
    cnv_rise("R4 hiz mid word");
    cnv_fall("R6 resume bit held");
    xfer(5, 7, 12'h2B4, "R6 second part");
    pulse(1'b1, "R3 past last bit");
    cnv_rise("R4 hiz");
    wait_done("R7 tag uses cfg from start");

    // partial write, then overwrite without read
    result = 8'h77;
    cnv_fall("R5 acq entry 5");
    xfer(0, 4, 12'hFFF, "R10 partial write");
    chk("R10 cfg kept", 32'(cfg), 32'h2B4);
    cnv_rise("R1 start 5");
    wait_done("R8 done 5");
    result = 8'h99;
    cnv_fall("R5 acq entry 6");
    cnv_rise("R1 start 6");
    wait_done("R8 done 6");
    cnv_fall("R5 acq entry 7");
    xfer(0, 12, 12'h000, "R8 unread word overwritten");
    chk("R2 cfg commit", 32'(cfg), 32'h000);
    cnv_rise("R1 start 7");
    wait_done("R9 done 7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule